// File: doc/BRIEF.md
# Type-A Proximity Reader Frame Encoder

This block turns a stream of bytes into the reader-to-card bit frame of a type-A proximity link and drives a single pause output. That output gates the 13.56 MHz carrier. A high level means the carrier is switched fully off. The block runs on the carrier clock, so one clock cycle is one carrier cycle. The bit period is 128, 64 or 32 cycles, depending on the selected rate. Every bit is coded as a short carrier pause placed at the start of the bit, or in its middle, or left out.

Bytes arrive on a valid/ready stream, least significant bit first. The first accepted byte opens a frame and also captures the rate and parity settings for the whole frame. The producer must keep bytes coming. Back-pressure rules: `s_ready` is high whenever the one-byte holding slot is empty and the frame can still take data. It is low from the transfer of a byte flagged last until the frame has finished. It is also low during the frame's closing symbols and in the one boundary cycle where the encoder looks for the next byte. A transfer occurs on a rising edge where both `s_valid` and `s_ready` are high. If the holding slot is empty when the next byte is due, the frame closes as if the previous byte had been the last. CRC bytes are sent as ordinary data.

Top module: `pcd_frame_encoder`

## Requirements
- R1: The bit period is 128 cycles at rate code 0, 64 cycles at code 1, and 32 cycles at codes 2 and 3.
- R2: Each pause lasts 40 cycles at code 0, 20 at code 1 and 10 at codes 2 and 3.
- R3: A logic 1 pauses from the half-bit point. A logic 0 pauses from the start of its bit when it opens the frame or follows another logic 0. A logic 0 that follows a logic 1 has no pause.
- R4: Data bits are sent least significant bit first.
- R5: Each complete byte is followed by a parity bit that makes the count of ones in those nine bits odd.
- R6: With `parity_off` high at the first transfer, neither the per-byte parity bits nor the closing parity bit are sent.
- R7: On the byte flagged last, `s_last_bits` of 1 to 7 sends only that many low-order bits, with no parity bit after them. A value of 0 sends all 8 bits.
- R8: At rate code 0 a frame is a logic-0 start symbol, then the data, then a logic-0 end symbol, then one bit period with no pause.
- R9: At rate codes 1 to 3 a frame is a logic-0 start bit, then the data, then a parity bit, then one bit period with no pause. That parity bit makes the count of ones over all data and per-byte parity bits even.
- R10: The first transfer starts the frame in the next cycle. Rate and parity settings are taken at that transfer only. `s_ready` stays low from the transfer of the last byte until the frame ends.
- R11: `busy` is high from the start symbol through the final idle period. `tx_done` is a one-cycle pulse in the last cycle of that period. After reset, `busy`, `tx_done` and `ask_pause` are low and `s_ready` is high.
- R12: If no byte is held when the next one is due, the frame ends with the closing symbols after the byte just sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Byte on `s_data` is offered |
| s_ready | output | 1 | Encoder can take a byte this cycle |
| s_data | input | 8 | Byte to send, bit 0 first |
| s_last | input | 1 | Offered byte closes the frame |
| s_last_bits | input | 3 | Valid low-order bits in the last byte, 0 means 8 |
| rate_sel | input | 2 | 0: 106 kbit/s, 1: 212 kbit/s, 2 or 3: 424 kbit/s |
| parity_off | input | 1 | Suppress all parity bits |
| ask_pause | output | 1 | High while the carrier must be paused |
| busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is the coding that depends on the previous bit. A logic 0 behaves differently after a 1 than after a 0, and each frame-opening symbol must pause at its start. The stimulus covers this with all-zero and all-one bytes, alternating patterns and random bytes at every rate. The bench rebuilds the expected pause waveform cycle by cycle from the bit list and compares it against the output. Other hard cases are the settings being captured only at the first transfer and the frame closing early on underrun. To reach them, the bench flips `rate_sel` and `parity_off` right after the first transfer, and in some frames it withholds both the last flag and any further byte.

// File: rtl/pcd_enc_pkg.sv
package pcd_enc_pkg;
  typedef enum logic [2:0] {
    SYM_START = 3'd0,
    SYM_DATA  = 3'd1,
    SYM_PAR   = 3'd2,
    SYM_TAIL  = 3'd3,
    SYM_GAP   = 3'd4
  } sym_kind_t;

  // rate code 3 is folded onto the fastest rate
  function automatic logic [1:0] rate_norm(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/pcd_bit_clock.sv
module pcd_bit_clock #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] period_m1,
  output logic [LW-1:0] cnt,
  output logic          bit_end
);
  assign bit_end = run && (cnt == period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (bit_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (cnt == '0)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= period_m1)); // R1
endmodule

// File: rtl/pcd_miller_shaper.sv
module pcd_miller_shaper
  import pcd_enc_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  sym_kind_t     kind,
  input  logic          val,
  input  logic          lead_zero,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] half,
  input  logic [LW-1:0] pause_len,
  output logic          pause
);
  logic [LW:0] mid_end;
  logic        early, late;

  assign mid_end = {1'b0, half} + {1'b0, pause_len};
  assign early   = !val && lead_zero && (cnt < pause_len);
  assign late    = val && (cnt >= half) && ({1'b0, cnt} < mid_end);
  assign pause   = active && (kind != SYM_GAP) && (early || late);

  // width tracker for the pause-length check
  logic [LW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (pause) run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  AST_PAUSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause) |-> (run_len == pause_len)); // R2
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == SYM_GAP) |=> !$rose(pause) || kind == SYM_START); // R8
endmodule

// File: rtl/pcd_symbol_seq.sv
module pcd_symbol_seq
  import pcd_enc_pkg::*;
#(
  parameter int BIT_106   = 128,
  parameter int PAUSE_106 = 40,
  parameter int LW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [2:0]    in_last_bits,
  input  logic [1:0]    rate_sel,
  input  logic          par_off,
  input  logic          bit_end,
  output logic          run,
  output sym_kind_t     kind,
  output logic          val,
  output logic          lead_zero,
  output logic [LW-1:0] period_m1,
  output logic [LW-1:0] half,
  output logic [LW-1:0] pause_len,
  output logic          done
);
  localparam logic [LW-1:0] BitLen   = LW'(BIT_106);
  localparam logic [LW-1:0] PauseLen = LW'(PAUSE_106);

  logic        run_q, paroff_q, first_q, prev_zero, acc;
  logic [1:0]  rate_q;
  sym_kind_t   kind_q;
  logic        val_q;
  logic [7:0]  hold_data, sh, cur_byte;
  logic [3:0]  hold_nb, bits_rem;
  logic        hold_full, hold_last, last_seen, cur_last, cur_par;

  // next-symbol decision
  sym_kind_t   nk;
  logic        nv, take, finish, shift_step, need_byte, accept;
  logic [3:0]  nb_in;

  always_comb begin
    nk         = kind_q;
    nv         = val_q;
    take       = 1'b0;
    finish     = 1'b0;
    shift_step = 1'b0;
    need_byte  = 1'b0;
    case (kind_q)
      SYM_START: need_byte = 1'b1;
      SYM_DATA: begin
        if (bits_rem > 4'd1) begin
          nk = SYM_DATA; nv = sh[1]; shift_step = 1'b1;
        end else if (cur_par) begin
          nk = SYM_PAR; nv = ~^cur_byte;
        end else begin
          need_byte = 1'b1;
        end
      end
      SYM_PAR:  need_byte = 1'b1;
      SYM_TAIL: begin nk = SYM_GAP; nv = 1'b0; end
      default:  finish = 1'b1;
    endcase
    if (need_byte) begin
      if (hold_full && !cur_last) begin
        take = 1'b1; nk = SYM_DATA; nv = hold_data[0];
      end else if (rate_q == 2'd0) begin
        nk = SYM_TAIL; nv = 1'b0;
      end else if (!paroff_q) begin
        nk = SYM_TAIL; nv = acc;
      end else begin
        nk = SYM_GAP; nv = 1'b0;
      end
    end
  end

  assign nb_in    = (in_last && in_last_bits != 3'd0) ? {1'b0, in_last_bits} : 4'd8;
  assign in_ready = !hold_full && !last_seen &&
                    !(run_q && (kind_q == SYM_TAIL || kind_q == SYM_GAP)) &&
                    !(bit_end && need_byte);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; paroff_q <= 1'b0; first_q <= 1'b0; prev_zero <= 1'b0;
      acc <= 1'b0; rate_q <= 2'd0; kind_q <= SYM_GAP; val_q <= 1'b0;
      hold_data <= '0; sh <= '0; cur_byte <= '0; hold_nb <= '0; bits_rem <= '0;
      hold_full <= 1'b0; hold_last <= 1'b0; last_seen <= 1'b0;
      cur_last <= 1'b0; cur_par <= 1'b0;
    end else begin
      if (accept) begin
        hold_data <= in_data;
        hold_last <= in_last;
        hold_nb   <= nb_in;
        hold_full <= 1'b1;
        if (in_last) last_seen <= 1'b1;
        if (!run_q) begin
          run_q     <= 1'b1;
          kind_q    <= SYM_START;
          val_q     <= 1'b0;
          first_q   <= 1'b1;
          prev_zero <= 1'b0;
          rate_q    <= rate_norm(rate_sel);
          paroff_q  <= par_off;
          acc       <= 1'b0;
          cur_last  <= 1'b0;
        end
      end
      if (bit_end) begin
        kind_q    <= nk;
        val_q     <= nv;
        first_q   <= 1'b0;
        prev_zero <= ~val_q;
        if (nk == SYM_DATA || nk == SYM_PAR) acc <= acc ^ nv;
        if (shift_step) begin
          sh       <= sh >> 1;
          bits_rem <= bits_rem - 4'd1;
        end
        if (take) begin
          sh        <= hold_data;
          cur_byte  <= hold_data;
          bits_rem  <= hold_nb;
          cur_last  <= hold_last;
          cur_par   <= (hold_nb == 4'd8) && !paroff_q;
          hold_full <= 1'b0;
        end
        if (finish) begin
          run_q     <= 1'b0;
          last_seen <= 1'b0;
        end
      end
    end
  end

  assign run       = run_q;
  assign kind      = kind_q;
  assign val       = val_q;
  assign lead_zero = first_q || prev_zero;
  assign period_m1 = (BitLen >> rate_q) - 1'b1;
  assign half      = BitLen >> (rate_q + 2'd1);
  assign pause_len = PauseLen >> rate_q;
  assign done      = run_q && (kind_q == SYM_GAP) && bit_end;

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> !in_ready); // R10
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ($stable(rate_q) && $stable(paroff_q))); // R10
  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (kind_q == SYM_START && first_q && !val_q)); // R8
  AST_TAIL_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && kind_q == SYM_TAIL && bit_end) |=> (kind_q == SYM_GAP)); // R9
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run_q); // R11
endmodule

// File: rtl/pcd_frame_encoder.sv
module pcd_frame_encoder
  import pcd_enc_pkg::*;
#(
  parameter int BIT_106   = 128,
  parameter int PAUSE_106 = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  input  logic [2:0] s_last_bits,
  input  logic [1:0] rate_sel,
  input  logic       parity_off,
  output logic       ask_pause,
  output logic       busy,
  output logic       tx_done
);
  localparam int LW = $clog2(BIT_106) + 1;

  logic          run, val, lead_zero, bit_end;
  sym_kind_t     kind;
  logic [LW-1:0] cnt, period_m1, half, pause_len;

  pcd_symbol_seq #(.BIT_106(BIT_106), .PAUSE_106(PAUSE_106), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .in_last(s_last), .in_last_bits(s_last_bits),
    .rate_sel(rate_sel), .par_off(parity_off),
    .bit_end(bit_end), .run(run), .kind(kind), .val(val), .lead_zero(lead_zero),
    .period_m1(period_m1), .half(half), .pause_len(pause_len), .done(tx_done)
  );

  pcd_bit_clock #(.LW(LW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .period_m1(period_m1),
    .cnt(cnt), .bit_end(bit_end)
  );

  pcd_miller_shaper #(.LW(LW)) u_shape (
    .clk(clk), .rst_n(rst_n), .active(run), .kind(kind), .val(val),
    .lead_zero(lead_zero), .cnt(cnt), .half(half), .pause_len(pause_len),
    .pause(ask_pause)
  );

  assign busy = run;

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ask_pause && !tx_done)); // R11
endmodule

// File: tb/pcd_frame_encoder_bench.sv
`timescale 1ns/1ps
module pcd_frame_encoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, parity_off = 1'b0;
  logic [7:0] s_data = '0;
  logic [2:0] s_last_bits = '0;
  logic [1:0] rate_sel = '0;
  logic s_ready, ask_pause, busy, tx_done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] bq [8];
  logic exp_v [96];
  int   exp_k [96];
  int   nsym;

  always #2.5 clk = ~clk;

  pcd_frame_encoder u_pcd_frame_encoder (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_last_bits(s_last_bits),
    .rate_sel(rate_sel), .parity_off(parity_off),
    .ask_pause(ask_pause), .busy(busy), .tx_done(tx_done)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add_sym(input logic v, input int k);
    exp_v[nsym] = v; exp_k[nsym] = k; nsym++;
  endtask

  function automatic logic exp_pause(input int k, input int off, input int p, input int pl);
    if (exp_v[k]) return (off >= p/2) && (off < p/2 + pl);
    return ((k == 0) || (exp_v[k-1] == 1'b0)) && (off < pl);
  endfunction

  task automatic build_exp(input int nb, input int rs, input logic po,
                           input logic [2:0] lb, input logic nolast);
    logic x;
    nsym = 0;
    add_sym(1'b0, 0);
    for (int i = 0; i < nb; i++) begin
      int nbits;
      nbits = (i == nb-1 && !nolast && lb != 3'd0) ? int'(lb) : 8;
      for (int b = 0; b < nbits; b++) add_sym(bq[i][b], 1);
      if (nbits == 8 && !po) add_sym(~^bq[i], 2);
    end
    if (rs == 0) add_sym(1'b0, 3);
    else if (!po) begin
      x = 1'b0;
      for (int k = 1; k < nsym; k++) x = x ^ exp_v[k];
      add_sym(x, 3);
    end
  endtask

  task automatic producer(input int nb, input logic [1:0] rate, input logic po,
                          input logic [2:0] lb, input logic nolast);
    logic rdy;
    rate_sel = rate; parity_off = po;
    for (int i = 0; i < nb; i++) begin
      s_valid = 1'b1; s_data = bq[i];
      s_last = (i == nb-1) && !nolast; s_last_bits = lb;
      rdy = 1'b0;
      while (!rdy) begin rdy = s_ready; @(negedge clk); end
      if (i == 0) begin rate_sel = ~rate; parity_off = ~po; end  // must be ignored (R10)
    end
    s_valid = 1'b0; s_last = 1'b0;
    if (!nolast) check(s_ready == 1'b0, "R10", "ready after last byte", s_ready, 0);
  endtask

  task automatic monitor(input int rs, input string tag);
    int p, pl, bad_off, waited;
    logic bad, bad_act, gap_ok;
    string req;
    p = 128 >> rs; pl = 40 >> rs;
    waited = 0;
    while (!ask_pause && waited < 4000) begin @(negedge clk); waited++; end
    check(ask_pause == 1'b1, tag, "start pause seen", ask_pause, 1);
    for (int k = 0; k < nsym; k++) begin
      bad = 1'b0; bad_off = 0; bad_act = 1'b0;
      for (int off = 0; off < p; off++) begin
        if (k != 0 || off != 0) @(negedge clk);
        if (!bad && (ask_pause !== exp_pause(k, off, p, pl) || busy !== 1'b1)) begin
          bad = 1'b1; bad_off = off; bad_act = ask_pause;
        end
      end
      case (exp_k[k])
        1: req = "R2 R3 R4";
        2: req = "R5";
        default: req = (rs == 0) ? "R8" : "R9";
      endcase
      check(!bad, req, $sformatf("%s symbol %0d pause at offset %0d", tag, k, bad_off),
            bad_act, exp_pause(k, bad_off, p, pl));
    end
    gap_ok = 1'b1;
    for (int off = 0; off < p; off++) begin
      @(negedge clk);
      if (ask_pause !== 1'b0 || busy !== 1'b1 || tx_done !== (off == p-1)) gap_ok = 1'b0;
    end
    check(gap_ok, tag, "idle period and done pulse timing", gap_ok, 1);
    @(negedge clk);
    check(busy == 1'b0 && tx_done == 1'b0, "R11", "busy and done after frame", busy, 0);
  endtask

  task automatic run_frame(input int nb, input logic [1:0] rate, input logic po,
                           input logic [2:0] lb, input logic nolast, input string tag);
    int rs;
    rs = (rate == 2'd3) ? 2 : int'(rate);
    build_exp(nb, rs, po, lb, nolast);
    fork
      producer(nb, rate, po, lb, nolast);
      monitor(rs, tag);
    join
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected frame completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !tx_done && !ask_pause && s_ready, "R11", "reset state",
          {busy, tx_done, ask_pause, s_ready}, 1);

    bq[0] = 8'h00;                          run_frame(1, 2'd0, 1'b0, 3'd0, 1'b0, "R8");
    bq[0] = 8'hA5; bq[1] = 8'hFF;           run_frame(2, 2'd1, 1'b0, 3'd0, 1'b0, "R9");
    bq[0] = 8'h3C; bq[1] = 8'hF5;           run_frame(2, 2'd2, 1'b0, 3'd3, 1'b0, "R7");
    bq[0] = 8'h81; bq[1] = 8'h7E;           run_frame(2, 2'd0, 1'b1, 3'd0, 1'b0, "R6");
    bq[0] = 8'h55;                          run_frame(1, 2'd3, 1'b1, 3'd7, 1'b0, "R1");
    bq[0] = 8'h12; bq[1] = 8'h34;           run_frame(2, 2'd1, 1'b0, 3'd0, 1'b1, "R12");
    bq[0] = 8'hFF;                          run_frame(1, 2'd0, 1'b0, 3'd1, 1'b0, "R7");
    for (int t = 0; t < 8; t++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      for (int i = 0; i < nb; i++) bq[i] = 8'($urandom);
      run_frame(nb, 2'($urandom), 1'($urandom), 3'($urandom), 1'b0, "R1 R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule